// File: doc/BRIEF.md
# Round-Robin Oscillator Lock Window Checker

This block decides, for each of three oscillators in turn, whether its frequency sits inside a lock-in window around a nominal value. The three oscillators are the first and second sound-carrier loops and the pilot-carrier loop. A single down-counter is shared by all three. The counter is loaded with a start value that depends on the loop and on the selected broadcast standard. It then counts rising edges of the selected oscillator for a fixed gate of reference clocks. The residual at the end of the gate is compared against an inclusive range.

A residual below the range means the oscillator ran fast, so the block issues a down-correction pulse for that loop. A residual above the range means it ran slow, so the block issues an up-correction pulse. A residual inside the range produces no pulse. Every out-of-window verdict also raises a one-cycle acquisition flag, which a downstream mute controller uses. The selection then moves to the next loop, and the scan repeats without end.

The gate length is a parameter, so the full three-loop cycle can be matched to the required cycle time. The default assumes a 4 MHz reference. The start values and the range limits arrive as flat tables.

Top module: `vco_window_scan`

## Requirements
- R1: While rst_n is low, and in the cycle after its release, corr_up, corr_dn and acq_flag are all 0. The first slot after reset measures loop 0.
- R2: Time is divided into slots of GATE_LEN reference cycles, and each slot measures one loop. Slots visit the loops in the order 0, 1, …, NUM_LOOPS-1, then return to 0. At most one acq_flag bit is high in any cycle.
- R3: In the first cycle of a slot, the counter loads the start entry for (std_sel, loop). An entry of any table with index std*NUM_LOOPS+loop occupies bits [index*CNT_W +: CNT_W] of that table.
- R4: Each oscillator passes through a two-flop synchroniser, and only rising edges of the selected oscillator decrement the counter. An edge that reaches the counter in cycles 2 through GATE_LEN of the slot counts; any other edge, and any edge of an unselected oscillator, has no effect.
- R5: The counter saturates at zero and never wraps.
- R6: The residual is compared against the entries lo and hi, taken with std_sel at the end of the slot. A residual below lo gives a down pulse on corr_dn of that loop. A residual above hi gives an up pulse on corr_up.
- R7: A residual with lo ≤ residual ≤ hi issues no pulse and no acquisition flag for that loop.
- R8: A correction pulse starts in the cycle right after the last cycle of the slot and lasts pulse_len cycles. pulse_len = 0 gives no pulse.
- R9: acq_flag of the measured loop is high for exactly one cycle, in the first pulse cycle, whenever the verdict is out of window, including when pulse_len is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_clk | input | NUM_LOOPS | Oscillator signals, asynchronous to clk_ref |
| std_sel | input | STD_W | Broadcast standard select |
| start_tbl | input | NUM_STD*NUM_LOOPS*CNT_W | Counter start values |
| lo_tbl | input | NUM_STD*NUM_LOOPS*CNT_W | Lower residual limits, inclusive |
| hi_tbl | input | NUM_STD*NUM_LOOPS*CNT_W | Upper residual limits, inclusive |
| pulse_len | input | PLS_W | Correction pulse length in reference cycles |
| corr_up | output | NUM_LOOPS | Per-loop raise-frequency pulse |
| corr_dn | output | NUM_LOOPS | Per-loop lower-frequency pulse |
| acq_flag | output | NUM_LOOPS | Per-loop one-cycle out-of-window flag |

## Verification
The bench builds the block with GATE_LEN=40, CNT_W=8, NUM_STD=2 and PLS_W=4. A short gate lets a complete three-loop round finish in 120 cycles, so many rounds fit in one run. It also makes edge counts small enough that a fast oscillator drives the counter into saturation at zero. Two standards are enough to show the table index changing the verdict. The 4-bit pulse length reaches both the zero-length case and pulses of several cycles.

// File: rtl/vws_pkg.sv
package vws_pkg;
  typedef enum logic [1:0] {
    VERD_NONE = 2'd0,
    VERD_UP   = 2'd1,
    VERD_DN   = 2'd2
  } verdict_e;
endpackage

// File: rtl/vws_sync.sv
// Two-flop synchroniser followed by a rising-edge detector.
module vws_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic meta_q, stab_q, last_q;
  logic meta_d, stab_d, last_d;

  always_comb begin
    meta_d = async_in;
    stab_d = meta_q;
    last_d = stab_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      stab_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= meta_d;
      stab_q <= stab_d;
      last_q <= last_d;
    end
  end

  assign rise = stab_q & ~last_q;
endmodule

// File: rtl/vws_sequencer.sv
// Slot timer and round-robin loop pointer.
module vws_sequencer #(
  parameter int NUM_LOOPS = 3,
  parameter int GATE_LEN  = 1024,
  localparam int SEL_W    = (NUM_LOOPS > 1) ? $clog2(NUM_LOOPS) : 1,
  localparam int GATE_W   = $clog2(GATE_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [SEL_W-1:0] sel,
  output logic             load,
  output logic             eval
);
  localparam logic [GATE_W-1:0] GATE_LAST = GATE_W'(GATE_LEN - 1);
  localparam logic [SEL_W-1:0]  SEL_LAST  = SEL_W'(NUM_LOOPS - 1);

  logic [GATE_W-1:0] gate_q, gate_d;
  logic [SEL_W-1:0]  sel_q, sel_d;

  assign load = (gate_q == '0);
  assign eval = (gate_q == GATE_LAST);
  assign sel  = sel_q;

  always_comb begin
    gate_d = gate_q;
    sel_d  = sel_q;
    if (eval) begin
      gate_d = '0;
      if (sel_q == SEL_LAST) sel_d = '0;
      else                   sel_d = sel_q + SEL_W'(1);
    end else begin
      gate_d = gate_q + GATE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= '0;
      sel_q  <= '0;
    end else begin
      gate_q <= gate_d;
      sel_q  <= sel_d;
    end
  end
endmodule

// File: rtl/vws_counter.sv
// Shared down-counter with table lookup and window comparison.
module vws_counter
  import vws_pkg::*;
#(
  parameter int NUM_LOOPS = 3,
  parameter int NUM_STD   = 4,
  parameter int CNT_W     = 12,
  localparam int SEL_W    = (NUM_LOOPS > 1) ? $clog2(NUM_LOOPS) : 1,
  localparam int STD_W    = (NUM_STD > 1) ? $clog2(NUM_STD) : 1,
  localparam int TBL_W    = NUM_STD * NUM_LOOPS * CNT_W,
  localparam int IDX_W    = $clog2(NUM_STD * NUM_LOOPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             eval,
  input  logic             rise,
  input  logic [SEL_W-1:0] sel,
  input  logic [STD_W-1:0] std_sel,
  input  logic [TBL_W-1:0] start_tbl,
  input  logic [TBL_W-1:0] lo_tbl,
  input  logic [TBL_W-1:0] hi_tbl,
  output logic [CNT_W-1:0] cnt,
  output verdict_e         verdict
);
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] start_v, lo_v, hi_v;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_dec;

  assign idx     = IDX_W'(std_sel) * IDX_W'(NUM_LOOPS) + IDX_W'(sel);
  assign start_v = start_tbl[int'(idx)*CNT_W +: CNT_W];
  assign lo_v    = lo_tbl[int'(idx)*CNT_W +: CNT_W];
  assign hi_v    = hi_tbl[int'(idx)*CNT_W +: CNT_W];

  always_comb begin
    cnt_dec = cnt_q;
    if (rise && (cnt_q != '0)) cnt_dec = cnt_q - CNT_W'(1);
  end

  always_comb begin
    if (load) cnt_d = start_v;
    else      cnt_d = cnt_dec;
  end

  always_comb begin
    verdict = VERD_NONE;
    if (eval) begin
      if (cnt_dec < lo_v)      verdict = VERD_DN;
      else if (cnt_dec > hi_v) verdict = VERD_UP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/vws_pulse.sv
// Per-loop correction pulse timer and acquisition flag.
module vws_pulse
  import vws_pkg::*;
#(
  parameter int PLS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  verdict_e         verdict,
  input  logic [PLS_W-1:0] pulse_len,
  output logic             up,
  output logic             dn,
  output logic             acq
);
  logic [PLS_W-1:0] tmr_q, tmr_d;
  logic             dir_q, dir_d;
  logic             acq_q, acq_d;
  logic             out_win;

  assign out_win = fire && (verdict != VERD_NONE);

  always_comb begin
    tmr_d = tmr_q;
    dir_d = dir_q;
    acq_d = out_win;
    if (fire) begin
      if (out_win) begin
        tmr_d = pulse_len;
        dir_d = (verdict == VERD_UP);
      end else begin
        tmr_d = '0;
      end
    end else if (tmr_q != '0) begin
      tmr_d = tmr_q - PLS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
      dir_q <= 1'b0;
      acq_q <= 1'b0;
    end else begin
      tmr_q <= tmr_d;
      dir_q <= dir_d;
      acq_q <= acq_d;
    end
  end

  assign up  = (tmr_q != '0) &&  dir_q;
  assign dn  = (tmr_q != '0) && !dir_q;
  assign acq = acq_q;
endmodule

// File: rtl/vco_window_scan.sv
module vco_window_scan
  import vws_pkg::*;
#(
  parameter int NUM_LOOPS = 3,
  parameter int NUM_STD   = 4,
  parameter int CNT_W     = 12,
  parameter int GATE_LEN  = 1024,
  parameter int PLS_W     = 8,
  localparam int STD_W    = (NUM_STD > 1) ? $clog2(NUM_STD) : 1,
  localparam int SEL_W    = (NUM_LOOPS > 1) ? $clog2(NUM_LOOPS) : 1,
  localparam int TBL_W    = NUM_STD * NUM_LOOPS * CNT_W
) (
  input  logic                 clk_ref,
  input  logic                 rst_n,
  input  logic [NUM_LOOPS-1:0] osc_clk,
  input  logic [STD_W-1:0]     std_sel,
  input  logic [TBL_W-1:0]     start_tbl,
  input  logic [TBL_W-1:0]     lo_tbl,
  input  logic [TBL_W-1:0]     hi_tbl,
  input  logic [PLS_W-1:0]     pulse_len,
  output logic [NUM_LOOPS-1:0] corr_up,
  output logic [NUM_LOOPS-1:0] corr_dn,
  output logic [NUM_LOOPS-1:0] acq_flag
);
  logic [NUM_LOOPS-1:0] rise_vec;
  logic                 rise_sel;
  logic [SEL_W-1:0]     loop_sel;
  logic                 slot_load, slot_eval;
  logic [CNT_W-1:0]     count_q;
  verdict_e             verdict;

  for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_sync
    vws_sync i_sync (
      .clk      (clk_ref),
      .rst_n    (rst_n),
      .async_in (osc_clk[g]),
      .rise     (rise_vec[g])
    );
  end

  always_comb begin
    rise_sel = 1'b0;
    for (int i = 0; i < NUM_LOOPS; i++) begin
      if (loop_sel == SEL_W'(i)) rise_sel = rise_vec[i];
    end
  end

  vws_sequencer #(
    .NUM_LOOPS (NUM_LOOPS),
    .GATE_LEN  (GATE_LEN)
  ) i_seq (
    .clk   (clk_ref),
    .rst_n (rst_n),
    .sel   (loop_sel),
    .load  (slot_load),
    .eval  (slot_eval)
  );

  vws_counter #(
    .NUM_LOOPS (NUM_LOOPS),
    .NUM_STD   (NUM_STD),
    .CNT_W     (CNT_W)
  ) i_cnt (
    .clk       (clk_ref),
    .rst_n     (rst_n),
    .load      (slot_load),
    .eval      (slot_eval),
    .rise      (rise_sel),
    .sel       (loop_sel),
    .std_sel   (std_sel),
    .start_tbl (start_tbl),
    .lo_tbl    (lo_tbl),
    .hi_tbl    (hi_tbl),
    .cnt       (count_q),
    .verdict   (verdict)
  );

  for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_pulse
    logic fire;
    assign fire = slot_eval && (loop_sel == SEL_W'(g));
    vws_pulse #(
      .PLS_W (PLS_W)
    ) i_pulse (
      .clk       (clk_ref),
      .rst_n     (rst_n),
      .fire      (fire),
      .verdict   (verdict),
      .pulse_len (pulse_len),
      .up        (corr_up[g]),
      .dn        (corr_dn[g]),
      .acq       (acq_flag[g])
    );
  end
endmodule

// File: rtl/vws_checks.sv
module vws_checks #(
  parameter int NUM_LOOPS = 3,
  parameter int CNT_W     = 12,
  parameter int PLS_W     = 8,
  localparam int SEL_W    = (NUM_LOOPS > 1) ? $clog2(NUM_LOOPS) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 load,
  input logic                 eval,
  input logic [SEL_W-1:0]     sel,
  input logic [CNT_W-1:0]     cnt,
  input logic [PLS_W-1:0]     pulse_len,
  input logic [NUM_LOOPS-1:0] corr_up,
  input logic [NUM_LOOPS-1:0] corr_dn,
  input logic [NUM_LOOPS-1:0] acq_flag
);
  localparam logic [SEL_W-1:0] SEL_LAST = SEL_W'(NUM_LOOPS - 1);

  a_r2_one_acq: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acq_flag));

  a_r2_sel_range: assert property (@(posedge clk) disable iff (!rst_n)
    sel <= SEL_LAST);

  a_r2_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !eval |=> $stable(sel));

  a_r2_sel_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && sel == SEL_LAST) |=> (sel == '0));

  a_r2_sel_step: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && sel != SEL_LAST) |=> (sel == $past(sel) + SEL_W'(1)));

  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (cnt <= $past(cnt)));

  for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
    a_r9_acq_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (acq_flag[g] && $past(pulse_len) != '0) |-> (corr_up[g] ^ corr_dn[g]));

    a_r8_up_needs_acq: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(corr_up[g]) |-> acq_flag[g]);

    a_r8_dn_needs_acq: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(corr_dn[g]) |-> acq_flag[g]);
  end
endmodule

bind vco_window_scan vws_checks #(
  .NUM_LOOPS (NUM_LOOPS),
  .CNT_W     (CNT_W),
  .PLS_W     (PLS_W)
) i_vws_checks (
  .clk       (clk_ref),
  .rst_n     (rst_n),
  .load      (slot_load),
  .eval      (slot_eval),
  .sel       (loop_sel),
  .cnt       (count_q),
  .pulse_len (pulse_len),
  .corr_up   (corr_up),
  .corr_dn   (corr_dn),
  .acq_flag  (acq_flag)
);

// File: tb/test_vco_window_scan.sv
module test_vco_window_scan;
  localparam int NL = 3;
  localparam int NS = 2;
  localparam int CW = 8;
  localparam int GL = 40;
  localparam int PW = 4;
  localparam int SW = 1;
  localparam int TW = NS * NL * CW;

  logic          clk;
  logic          rst_n;
  logic [NL-1:0] osc;
  logic [SW-1:0] std_sel;
  logic [TW-1:0] start_tbl, lo_tbl, hi_tbl;
  logic [PW-1:0] pulse_len;
  logic [NL-1:0] corr_up, corr_dn, acq_flag;

  vco_window_scan #(
    .NUM_LOOPS (NL), .NUM_STD (NS), .CNT_W (CW), .GATE_LEN (GL), .PLS_W (PW)
  ) i_vco_window_scan (
    .clk_ref (clk), .rst_n (rst_n), .osc_clk (osc), .std_sel (std_sel),
    .start_tbl (start_tbl), .lo_tbl (lo_tbl), .hi_tbl (hi_tbl),
    .pulse_len (pulse_len), .corr_up (corr_up), .corr_dn (corr_dn),
    .acq_flag (acq_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Oscillator generators: half period in reference cycles, 0 = stopped.
  int hp [NL];
  int ph [NL];
  initial begin
    osc = '0;
    for (int i = 0; i < NL; i++) begin hp[i] = 0; ph[i] = 0; end
  end
  always @(negedge clk) begin
    for (int i = 0; i < NL; i++) begin
      if (hp[i] != 0) begin
        ph[i]++;
        if (ph[i] >= hp[i]) begin osc[i] = ~osc[i]; ph[i] = 0; end
      end
    end
  end

  function automatic int tget(input logic [TW-1:0] t, input int s, input int l);
    return int'(t[(s*NL+l)*CW +: CW]);
  endfunction

  task automatic set_entry(input int s, input int l, input int st, input int lo, input int hi);
    start_tbl[(s*NL+l)*CW +: CW] = CW'(st);
    lo_tbl[(s*NL+l)*CW +: CW]    = CW'(lo);
    hi_tbl[(s*NL+l)*CW +: CW]    = CW'(hi);
  endtask

  // Behavioural reference model.
  int m_gate, m_sel, m_cnt;
  int m_tmr [NL];
  bit m_dir [NL];
  bit m_acq [NL];
  bit m_p1 [NL];
  bit m_p2 [NL];
  bit m_p3 [NL];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_gate = 0; m_sel = 0; m_cnt = 0;
      for (int i = 0; i < NL; i++) begin
        m_tmr[i] = 0; m_dir[i] = 0; m_acq[i] = 0;
        m_p1[i] = 0; m_p2[i] = 0; m_p3[i] = 0;
      end
    end else begin
      bit rs;
      int nc;
      rs = m_p2[m_sel] && !m_p3[m_sel];
      for (int i = 0; i < NL; i++) begin
        if (m_tmr[i] > 0) m_tmr[i]--;
        m_acq[i] = 0;
      end
      if (m_gate == 0) begin
        m_cnt = tget(start_tbl, int'(std_sel), m_sel);
        m_gate = 1;
      end else begin
        nc = m_cnt;
        if (rs && nc > 0) nc--;
        if (m_gate == GL - 1) begin
          if (nc < tget(lo_tbl, int'(std_sel), m_sel)) begin
            m_tmr[m_sel] = int'(pulse_len); m_dir[m_sel] = 0; m_acq[m_sel] = 1;
          end else if (nc > tget(hi_tbl, int'(std_sel), m_sel)) begin
            m_tmr[m_sel] = int'(pulse_len); m_dir[m_sel] = 1; m_acq[m_sel] = 1;
          end else begin
            m_tmr[m_sel] = 0;
          end
          m_sel = (m_sel + 1) % NL;
          m_gate = 0;
        end else begin
          m_cnt = nc;
          m_gate++;
        end
      end
      for (int i = 0; i < NL; i++) begin
        m_p3[i] = m_p2[i]; m_p2[i] = m_p1[i]; m_p1[i] = osc[i];
      end
    end
  end

  // Per-cycle comparison and observation counters.
  int seen_up [NL];
  int seen_dn [NL];
  int seen_acq [NL];
  int acq_q [$];

  task automatic clear_seen();
    for (int i = 0; i < NL; i++) begin seen_up[i] = 0; seen_dn[i] = 0; seen_acq[i] = 0; end
    acq_q.delete();
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NL; i++) begin
        bit eu, ed;
        eu = (m_tmr[i] > 0) && m_dir[i];
        ed = (m_tmr[i] > 0) && !m_dir[i];
        check(corr_up[i] === eu, $sformatf("R6 corr_up[%0d]", i), int'(corr_up[i]), int'(eu));
        check(corr_dn[i] === ed, $sformatf("R6 corr_dn[%0d]", i), int'(corr_dn[i]), int'(ed));
        check(acq_flag[i] === m_acq[i], $sformatf("R9 acq_flag[%0d]", i), int'(acq_flag[i]), int'(m_acq[i]));
        if (corr_up[i]) seen_up[i]++;
        if (corr_dn[i]) seen_dn[i]++;
        if (acq_flag[i]) begin seen_acq[i]++; acq_q.push_back(i); end
      end
    end
  end

  task automatic run_window();
    repeat (3 * GL) @(negedge clk);
    clear_seen();
    repeat (6 * GL) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    std_sel = '0;
    pulse_len = PW'(5);
    start_tbl = '0; lo_tbl = '0; hi_tbl = '0;
    for (int s = 0; s < NS; s++)
      for (int l = 0; l < NL; l++) set_entry(s, l, 100, 85, 95);
    hp[0] = 0; hp[1] = 2; hp[2] = 2;
    clear_seen();
    repeat (4) @(negedge clk);
    // R1: reset state
    check(corr_up === '0, "R1 corr_up in reset", int'(corr_up), 0);
    check(corr_dn === '0, "R1 corr_dn in reset", int'(corr_dn), 0);
    check(acq_flag === '0, "R1 acq_flag in reset", int'(acq_flag), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check((corr_up | corr_dn | acq_flag) === '0, "R1 outputs after release", 0, 0);
    repeat (GL + 2) @(negedge clk);
    check(acq_q.size() == 1 && acq_q[0] == 0, "R1 first slot measures loop 0",
          (acq_q.size() > 0) ? acq_q[0] : -1, 0);

    // Loop 0 stopped, loop 1 fast, loop 2 nominal.
    hp[0] = 0; hp[1] = 1; hp[2] = 2;
    run_window();
    check(seen_up[0] > 0 && seen_dn[0] == 0, "R4 R6 stopped loop 0 raised", seen_up[0], 10);
    check(seen_dn[1] > 0 && seen_up[1] == 0, "R6 fast loop 1 lowered", seen_dn[1], 10);
    check(seen_up[2] == 0 && seen_dn[2] == 0 && seen_acq[2] == 0, "R7 loop 2 in window",
          seen_acq[2], 0);
    check(seen_up[0] == 10, "R8 pulse length 5 twice", seen_up[0], 10);

    // Saturation: small start, fast oscillator.
    set_entry(0, 1, 3, 1, 2);
    run_window();
    check(seen_dn[1] > 0, "R5 saturated residual below range", seen_dn[1], 10);

    // Zero-length pulses still flag.
    pulse_len = '0;
    run_window();
    check(seen_acq[0] == 2 && seen_up[0] == 0, "R8 zero pulse length", seen_up[0], 0);
    check(seen_acq[0] == 2, "R9 flag with zero pulse", seen_acq[0], 2);

    // Second standard puts the stopped loop 0 inside its window.
    pulse_len = PW'(7);
    set_entry(1, 0, 50, 45, 55);
    std_sel = 1'b1;
    run_window();
    check(seen_acq[0] == 0 && seen_up[0] == 0, "R3 standard selects table entry", seen_acq[0], 0);

    // All loops stopped: every slot out of window, order must rotate.
    std_sel = 1'b0;
    set_entry(0, 1, 100, 85, 95);
    hp[0] = 0; hp[1] = 0; hp[2] = 0;
    run_window();
    check(acq_q.size() == 6, "R2 one flag per slot", acq_q.size(), 6);
    for (int k = 1; k < acq_q.size(); k++)
      check(acq_q[k] == (acq_q[k-1] + 1) % NL, "R2 round-robin order", acq_q[k],
            (acq_q[k-1] + 1) % NL);

    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule